// File: doc/BRIEF.md
# Performance Monitor Counter Unit

This block counts cycles and selected hardware events so that software can measure how a processor core behaves. It has one free-running cycle counter and two event counters, each 32 bits wide. One control register gathers everything that steers them: a global run bit, one-shot clears, a divide-by-64 option for the cycle counter, per-counter interrupt enables, sticky overflow flags and the two 8-bit event select codes.

Each event counter watches a bank of single-cycle event strobes. The select code is the index of the strobe to count, and the code 0xFF means "count nothing". Software can preload any counter through the register port, so that it overflows after a chosen sampling period. An overflow raises a sticky flag, and a flag whose interrupt enable is set drives a level interrupt.

The register port is a simple write strobe with a 2-bit address and a combinational read-data output. Address 0 is control, 1 is the cycle count, 2 is event count 0 and 3 is event count 1.

Top module: `perf_mon_unit`

## Requirements
- R1: After reset the control register reads 0x0FFFF000 (both select codes 0xFF, every other field zero), all three counters read 0 and `irq` is low.
- R2: Control bit 0 is the global run bit. While it is 0 no counter changes except by a register write. While it is 1 and bit 3 is 0, the cycle counter (address 1) adds one on every clock edge.
- R3: Writing address 1, 2 or 3 loads the written value into the cycle counter, event counter 0 or event counter 1. A load takes priority over an increment in the same cycle.
- R4: Event counter 0 uses the select code in control bits 19:12, and event counter 1 uses bits 27:20. While running, a counter adds one on each clock edge at which `evt_strobe[code]` is high. Code 0xFF makes the counter hold its value.
- R5: Writing 1 to control bit 1 clears both event counters, and writing 1 to bit 2 clears the cycle counter (and its prescaler). Both bits always read 0. A clear wins over an increment in the same cycle. Bit 1 leaves the cycle counter untouched.
- R6: With control bit 3 set, the cycle counter advances once per 64 running clock edges, on the 64th, 128th and so on since the prescaler was last cleared.
- R7: A counter that wraps from 0xFFFFFFFF to 0 sets its sticky flag: bit 8 for event counter 0, bit 9 for event counter 1, bit 10 for the cycle counter. Writing 1 to a flag bit clears it, writing 0 leaves it alone. A wrap in the same cycle as a clear leaves the flag set. The wrap of one counter never clears the flag of another.
- R8: `irq` is high whenever some flag is set and its enable is set. The enables are bit 4 for event counter 0, bit 5 for event counter 1 and bit 6 for the cycle counter. `irq` stays high until every enabled pending flag is cleared.
- R9: Control bits 31:28, 11 and 7 always read 0, and writing them has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 control, 1 cycle, 2 event 0, 3 event 1) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| evt_strobe | input | EVT_W | Bank of single-cycle event strobes |
| irq | output | 1 | Level interrupt |

## Verification
Any wrong internal state shows at the ports within the cycle after the edge where it arises. A miscounting counter or a wrongly routed select code shows up as a wrong value at addresses 1 to 3 on the next read. A lost or wrongly cleared flag shows up in bits 10:8 of the control read and, when enabled, on `irq` in the same cycle. Prescaler errors take longest to appear, one 64-edge period, so the bench runs the divided mode over two full periods and checks the exact count.

// File: rtl/pmu_pkg.sv
package pmu_pkg;

  localparam int REG_W  = 32;
  localparam int SEL_W  = 8;
  localparam int N_EVC  = 2;

  // control field positions (software decodes these)
  localparam int B_RUN   = 0;
  localparam int B_EVCLR = 1;
  localparam int B_CYCLR = 2;
  localparam int B_DIV   = 3;
  localparam int B_IE    = 4;   // 3 bits: ev0, ev1, cyc
  localparam int B_OVF   = 8;   // 3 bits: ev0, ev1, cyc
  localparam int B_SEL0  = 12;
  localparam int B_SEL1  = 20;

  localparam logic [REG_W-1:0] RESV_MASK = 32'hF000_0880;
  localparam logic [SEL_W-1:0] NO_EVENT  = '1;

  typedef enum logic [1:0] {
    A_CTRL = 2'd0,
    A_CYC  = 2'd1,
    A_EV0  = 2'd2,
    A_EV1  = 2'd3
  } reg_addr_e;

  function automatic logic [REG_W-1:0] pack_ctrl(
    input logic             run,
    input logic             div,
    input logic [2:0]       ie,
    input logic [2:0]       ovf,
    input logic [SEL_W-1:0] s0,
    input logic [SEL_W-1:0] s1);
    logic [REG_W-1:0] r;
    r = '0;
    r[B_RUN]          = run;
    r[B_DIV]          = div;
    r[B_IE +: 3]      = ie;
    r[B_OVF +: 3]     = ovf;
    r[B_SEL0 +: SEL_W] = s0;
    r[B_SEL1 +: SEL_W] = s1;
    return r;
  endfunction

  // sticky flags: set beats write-one-to-clear
  function automatic logic [2:0] flag_next(
    input logic [2:0] cur,
    input logic [2:0] clr_mask,
    input logic [2:0] set);
    return (cur & ~clr_mask) | set;
  endfunction

endpackage

// File: rtl/pmu_counter.sv
module pmu_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         inc,
  output logic [W-1:0] val,
  output logic         wrap
);

  logic [W-1:0] cnt_q;

  assign val  = cnt_q;
  assign wrap = inc & ~clr & ~load & (&cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clr)    cnt_q <= '0;
    else if (load)   cnt_q <= load_val;
    else if (inc)    cnt_q <= cnt_q + W'(1);
  end

  // R5
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0));

  // R3
  load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !clr) |=> (cnt_q == $past(load_val)));

endmodule

// File: rtl/pmu_evt_sel.sv
module pmu_evt_sel #(
  parameter int EVT_W = 256,
  parameter int SEL_W = 8
) (
  input  logic [EVT_W-1:0] bank,
  input  logic [SEL_W-1:0] code,
  input  logic             run,
  output logic             hit
);

  localparam int SPAN = 1 << SEL_W;   // EVT_W must not exceed SPAN

  logic [SPAN-1:0] padded;

  always_comb begin
    padded = '0;
    for (int i = 0; i < EVT_W; i++) padded[i] = bank[i];
  end

  assign hit = run && (code != {SEL_W{1'b1}}) && padded[code];

endmodule

// File: rtl/pmu_prescale.sv
module pmu_prescale #(
  parameter int PW = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic tick
);

  logic [PW-1:0] pre_q;

  assign tick = run & (&pre_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pre_q <= '0;
    else if (clr)  pre_q <= '0;
    else if (run)  pre_q <= pre_q + PW'(1);
  end

  // R6
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

endmodule

// File: rtl/perf_mon_unit.sv
module perf_mon_unit
  import pmu_pkg::*;
#(
  parameter int CNT_W    = 32,   // at most REG_W
  parameter int EVT_W    = 256,  // at most 2**SEL_W
  parameter int DIV_LOG2 = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [1:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic [EVT_W-1:0] evt_strobe,
  output logic             irq
);

  // control state
  logic             run_q, div_q;
  logic [2:0]       ie_q, flag_q;
  logic [SEL_W-1:0] sel_q [N_EVC];

  // internal events, named for the assertions
  logic             ctrl_wr, evt_clr, cyc_clr;
  logic             pre_tick, cyc_inc, cyc_wrap, cyc_load;
  logic [CNT_W-1:0] cyc_val;
  logic [CNT_W-1:0] ev_val [N_EVC];
  logic [N_EVC-1:0] ev_hit, ev_wrap, ev_load;

  logic unused_wbits;
  assign unused_wbits = ^{reg_wdata[31:28], reg_wdata[11], reg_wdata[7]};

  assign ctrl_wr  = reg_we && (reg_addr == A_CTRL);
  assign evt_clr  = ctrl_wr && reg_wdata[B_EVCLR];
  assign cyc_clr  = ctrl_wr && reg_wdata[B_CYCLR];
  assign cyc_load = reg_we && (reg_addr == A_CYC);

  // cycle counter path
  pmu_prescale #(.PW(DIV_LOG2)) u_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (cyc_clr),
    .run  (run_q & div_q),
    .tick (pre_tick)
  );

  assign cyc_inc = run_q & (div_q ? pre_tick : 1'b1);

  pmu_counter #(.W(CNT_W)) u_cyc (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (cyc_clr),
    .load    (cyc_load),
    .load_val(reg_wdata[CNT_W-1:0]),
    .inc     (cyc_inc),
    .val     (cyc_val),
    .wrap    (cyc_wrap)
  );

  // event counters
  for (genvar k = 0; k < N_EVC; k++) begin : g_evc
    localparam logic [1:0] ADDR_K = 2'(k + 2);

    assign ev_load[k] = reg_we && (reg_addr == ADDR_K);

    pmu_evt_sel #(.EVT_W(EVT_W), .SEL_W(SEL_W)) u_sel (
      .bank(evt_strobe),
      .code(sel_q[k]),
      .run (run_q),
      .hit (ev_hit[k])
    );

    pmu_counter #(.W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (evt_clr),
      .load    (ev_load[k]),
      .load_val(reg_wdata[CNT_W-1:0]),
      .inc     (ev_hit[k]),
      .val     (ev_val[k]),
      .wrap    (ev_wrap[k])
    );

    // R4
    idle_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_q[k] == NO_EVENT && !evt_clr && !ev_load[k]) |=> $stable(ev_val[k]));

    // R7
    ev_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev_wrap[k] |=> flag_q[k]);
  end

  // control register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      div_q    <= 1'b0;
      ie_q     <= '0;
      flag_q   <= '0;
      sel_q[0] <= NO_EVENT;
      sel_q[1] <= NO_EVENT;
    end else begin
      flag_q <= flag_next(flag_q,
                          ctrl_wr ? reg_wdata[B_OVF +: 3] : 3'b000,
                          {cyc_wrap, ev_wrap});
      if (ctrl_wr) begin
        run_q    <= reg_wdata[B_RUN];
        div_q    <= reg_wdata[B_DIV];
        ie_q     <= reg_wdata[B_IE +: 3];
        sel_q[0] <= reg_wdata[B_SEL0 +: SEL_W];
        sel_q[1] <= reg_wdata[B_SEL1 +: SEL_W];
      end
    end
  end

  assign irq = |(flag_q & ie_q);

  // read mux
  always_comb begin
    case (reg_addr_e'(reg_addr))
      A_CTRL:  reg_rdata = pack_ctrl(run_q, div_q, ie_q, flag_q, sel_q[0], sel_q[1]);
      A_CYC:   reg_rdata = 32'(cyc_val);
      A_EV0:   reg_rdata = 32'(ev_val[0]);
      default: reg_rdata = 32'(ev_val[1]);
    endcase
  end

  // R2
  halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !reg_we) |=> $stable(cyc_val));

  // R7
  cyc_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_wrap |=> flag_q[2]);

  // R8
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !ctrl_wr) |=> irq);

  // R9
  resv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == A_CTRL) |-> ((reg_rdata & RESV_MASK) == '0));

endmodule

// File: tb/test_perf_mon_unit.sv
module test_perf_mon_unit;

  localparam int EVT_W = 256;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             reg_we = 1'b0;
  logic [1:0]       reg_addr = 2'd0;
  logic [31:0]      reg_wdata = '0;
  logic [31:0]      reg_rdata;
  logic [EVT_W-1:0] evt_strobe = '0;
  logic             irq;

  always #5 clk = ~clk;   // 100 MHz

  perf_mon_unit #(.EVT_W(EVT_W)) i_perf_mon_unit (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .evt_strobe(evt_strobe), .irq(irq)
  );

  // scoreboard queues
  bit          q_kind [$];   // 0: read data, 1: irq
  logic [31:0] q_exp  [$];
  string       q_tag  [$];

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [31:0] m_got, m_exp;
  bit          m_kind;
  string       m_tag;

  // monitor: compares each expected item at the falling edge
  always @(negedge clk) begin
    while (q_exp.size() != 0) begin
      m_kind = q_kind.pop_front();
      m_exp  = q_exp.pop_front();
      m_tag  = q_tag.pop_front();
      m_got  = m_kind ? {31'b0, irq} : reg_rdata;
      n_chk++;
      if (m_got !== m_exp) begin
        n_fail++;
        $display("FAIL %s: got %h expected %h", m_tag, m_got, m_exp);
      end
    end
  end

  // bench-side control word builder (fields per the requirements)
  function automatic logic [31:0] cw(bit run, bit div, logic [2:0] ie,
                                     logic [7:0] s0, logic [7:0] s1);
    return {4'h0, s1, s0, 4'h0, 1'b0, ie, div, 2'b00, run};
  endfunction

  task automatic expect_rd(input logic [1:0] a, input logic [31:0] e, input string tag);
    @(posedge clk); #1;
    reg_addr = a;
    q_kind.push_back(1'b0); q_exp.push_back(e); q_tag.push_back(tag);
    @(negedge clk); #1;
  endtask

  task automatic expect_irq(input bit e, input string tag);
    @(posedge clk); #1;
    q_kind.push_back(1'b1); q_exp.push_back({31'b0, e}); q_tag.push_back(tag);
    @(negedge clk); #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d, input int evt_idx = -1);
    @(posedge clk); #1;
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    if (evt_idx >= 0) evt_strobe[evt_idx] = 1'b1;
    @(posedge clk); #1;
    reg_we = 1'b0; evt_strobe = '0;
  endtask

  task automatic pulse(input int idx);
    @(posedge clk); #1;
    evt_strobe[idx] = 1'b1;
    @(posedge clk); #1;
    evt_strobe = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got hang expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    expect_rd(2'd0, 32'h0FFF_F000, "R1 ctrl after reset");
    expect_rd(2'd1, 32'h0, "R1 cycle after reset");
    expect_rd(2'd2, 32'h0, "R1 ev0 after reset");
    expect_rd(2'd3, 32'h0, "R1 ev1 after reset");
    expect_irq(1'b0, "R1 irq after reset");

    // R2 stopped: nothing moves
    repeat (5) @(posedge clk);
    expect_rd(2'd1, 32'h0, "R2 cycle holds while stopped");

    // R2 running: 12 enabled edges
    wr(2'd0, cw(1, 0, 3'b000, 8'hFF, 8'hFF));
    repeat (10) @(posedge clk);
    wr(2'd0, cw(0, 0, 3'b000, 8'hFF, 8'hFF));
    expect_rd(2'd1, 32'd12, "R2 cycle count over 12 edges");
    expect_rd(2'd2, 32'h0, "R4 ev0 holds with code FF");

    // R3 preload
    wr(2'd1, 32'hFFFF_FFFE);
    wr(2'd2, 32'h1111_1111);
    wr(2'd3, 32'h2222_2222);
    expect_rd(2'd1, 32'hFFFF_FFFE, "R3 cycle preload");
    expect_rd(2'd2, 32'h1111_1111, "R3 ev0 preload");
    expect_rd(2'd3, 32'h2222_2222, "R3 ev1 preload");

    // R7 and R8: cycle counter wraps after two edges
    wr(2'd0, cw(1, 0, 3'b100, 8'hFF, 8'hFF));
    wr(2'd0, cw(0, 0, 3'b100, 8'hFF, 8'hFF));
    expect_rd(2'd1, 32'h0, "R7 cycle wrapped to zero");
    expect_rd(2'd0, cw(0, 0, 3'b100, 8'hFF, 8'hFF) | (32'h1 << 10), "R7 cycle flag set");
    expect_irq(1'b1, "R8 irq on enabled cycle flag");

    // R7 write-one-to-clear
    wr(2'd0, cw(0, 0, 3'b100, 8'hFF, 8'hFF) | (32'h1 << 10));
    expect_rd(2'd0, cw(0, 0, 3'b100, 8'hFF, 8'hFF), "R7 cycle flag cleared");
    expect_irq(1'b0, "R8 irq drops after clear");

    // R4 event selection
    wr(2'd0, cw(1, 0, 3'b000, 8'h07, 8'h0B));
    pulse(7); pulse(7); pulse(7);
    pulse(11); pulse(11);
    pulse(5);
    wr(2'd0, cw(0, 0, 3'b000, 8'h07, 8'h0B));
    expect_rd(2'd2, 32'h1111_1114, "R4 ev0 counts strobe 7");
    expect_rd(2'd3, 32'h2222_2224, "R4 ev1 counts strobe 11");

    // R2 stopped: selected strobe ignored
    pulse(7);
    expect_rd(2'd2, 32'h1111_1114, "R2 ev0 holds while stopped");

    // R4 code FF holds even with strobe 255
    wr(2'd0, cw(1, 0, 3'b000, 8'hFF, 8'h0B));
    pulse(255); pulse(7);
    wr(2'd0, cw(0, 0, 3'b000, 8'hFF, 8'h0B));
    expect_rd(2'd2, 32'h1111_1114, "R4 ev0 holds with code FF");

    // R5 event clear leaves cycle counter
    wr(2'd1, 32'h0000_1234);
    wr(2'd0, cw(0, 0, 3'b000, 8'hFF, 8'hFF) | 32'h2);
    expect_rd(2'd2, 32'h0, "R5 ev0 cleared");
    expect_rd(2'd3, 32'h0, "R5 ev1 cleared");
    expect_rd(2'd1, 32'h0000_1234, "R5 cycle untouched by event clear");
    expect_rd(2'd0, cw(0, 0, 3'b000, 8'hFF, 8'hFF), "R5 clear bits read zero");

    // R5 cycle clear
    wr(2'd0, cw(0, 0, 3'b000, 8'hFF, 8'hFF) | 32'h4);
    expect_rd(2'd1, 32'h0, "R5 cycle cleared");

    // R5 clear wins over same-cycle increment
    wr(2'd2, 32'd5);
    wr(2'd0, cw(1, 0, 3'b000, 8'h07, 8'hFF));
    wr(2'd0, cw(1, 0, 3'b000, 8'h07, 8'hFF) | 32'h2, 7);
    wr(2'd0, cw(0, 0, 3'b000, 8'h07, 8'hFF));
    expect_rd(2'd2, 32'h0, "R5 clear beats increment");

    // R7 set beats same-cycle clear
    wr(2'd2, 32'hFFFF_FFFF);
    wr(2'd0, cw(1, 0, 3'b000, 8'h07, 8'hFF));
    wr(2'd0, cw(1, 0, 3'b000, 8'h07, 8'hFF) | (32'h1 << 8), 7);
    wr(2'd0, cw(0, 0, 3'b000, 8'h07, 8'hFF));
    expect_rd(2'd2, 32'h0, "R7 ev0 wrapped");
    expect_rd(2'd0, cw(0, 0, 3'b000, 8'h07, 8'hFF) | (32'h1 << 8), "R7 set beats clear");

    // R7 no cross clear
    wr(2'd3, 32'hFFFF_FFFF);
    wr(2'd0, cw(1, 0, 3'b000, 8'h07, 8'h0B));
    pulse(11);
    wr(2'd0, cw(0, 0, 3'b000, 8'h07, 8'h0B));
    expect_rd(2'd0, cw(0, 0, 3'b000, 8'h07, 8'h0B) | (32'h3 << 8), "R7 both flags held");
    expect_irq(1'b0, "R8 irq masked with enables off");

    // R8 masking
    wr(2'd0, cw(0, 0, 3'b010, 8'h07, 8'h0B));
    expect_irq(1'b1, "R8 irq for ev1 flag");
    wr(2'd0, cw(0, 0, 3'b010, 8'h07, 8'h0B) | (32'h1 << 9));
    expect_irq(1'b0, "R8 irq low with only masked flag left");
    expect_rd(2'd0, cw(0, 0, 3'b010, 8'h07, 8'h0B) | (32'h1 << 8), "R8 ev0 flag still pending");

    // R9 reserved bits
    wr(2'd0, cw(0, 0, 3'b000, 8'hFF, 8'hFF) | 32'hF000_0880);
    expect_rd(2'd0, cw(0, 0, 3'b000, 8'hFF, 8'hFF) | (32'h1 << 8), "R9 reserved bits read zero");

    // R6 divided mode: 130 running edges
    wr(2'd0, cw(1, 1, 3'b000, 8'hFF, 8'hFF) | 32'h4);
    repeat (128) @(posedge clk);
    wr(2'd0, cw(0, 1, 3'b000, 8'hFF, 8'hFF));
    expect_rd(2'd1, 32'd2, "R6 divide-by-64 count");
    expect_rd(2'd0, cw(0, 1, 3'b000, 8'hFF, 8'hFF) | (32'h1 << 8), "R6 divide bit reads back");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule